// File: doc/BRIEF.md
# Quadword Register-Pair Store Sequencer

This block carries out a 128-bit store whose source is a pair of general-purpose registers. The pair is an even-numbered register and the odd-numbered register that follows it. The store goes out as two 64-bit doubleword writes on a memory port that uses a valid/ready handshake. For each request the caller supplies the following:

- the even register number and the values of both registers;
- a base value, with a flag that replaces the base by zero;
- a signed displacement that counts in units of four bytes;
- the current endian mode.

The effective address is the selected base plus the displacement. The displacement is sign-extended and shifted left by two bits.

The endian mode decides two things: which register goes to which doubleword, and whether its bytes are reversed. The two writes always go out in ascending address order. The block raises a one-cycle done pulse when the second write has been accepted. A request that names an odd register is rejected with an invalid-form pulse, and no writes are issued.

Top module: `qw_pair_store`

## Requirements
- R1: The first beat address equals (req_base_zero ? 0 : req_base) plus req_ds sign-extended from bit 13 with two zero bits appended below it, modulo 2^64.
- R2: In big-endian mode (req_little_endian = 0), the first beat carries the even register value unmodified, at the effective address.
- R3: The second beat is addressed at the first beat address plus 8, in both modes. In big-endian mode it carries the odd register value unmodified.
- R4: In little-endian mode, the first beat carries the odd register value byte-reversed. Byte k (bits 8k+7:8k) of the beat equals byte 7-k of the register.
- R5: In little-endian mode, the second beat carries the even register value byte-reversed, with the same byte mapping as R4.
- R6: While wr_valid is high and wr_ready is low, wr_valid, wr_addr and wr_data hold their values. The second beat is not presented until the first has been accepted.
- R7: A request whose register number has bit 0 set raises bad_form for exactly one cycle, in the cycle after acceptance. No beat is issued and busy stays low.
- R8: busy is high and req_ready is low from the cycle after a request is accepted until the done cycle, inclusive. A request offered while busy is ignored: the store in progress and bad_form are unaffected.
- R9: done is a one-cycle pulse in the cycle after the second beat is accepted. In the cycle after done, busy is low and req_ready is high.
- R10: When rst_n is low at a clock edge, the block returns to idle: wr_valid, done, busy and bad_form are low and req_ready is high. This also aborts a store in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_reg | input | 5 | Register number of the first register of the pair (must be even) |
| req_even_val | input | 64 | Value of the even register |
| req_odd_val | input | 64 | Value of the odd register |
| req_base | input | 64 | Base value |
| req_ds | input | 14 | Signed displacement, in units of four bytes |
| req_base_zero | input | 1 | Use zero in place of the base |
| req_little_endian | input | 1 | Endian mode: 1 little-endian, 0 big-endian |
| wr_valid | output | 1 | Write beat valid |
| wr_ready | input | 1 | Memory port accepts the beat |
| wr_addr | output | 64 | Byte address of the doubleword |
| wr_data | output | 64 | Doubleword data |
| done | output | 1 | One-cycle pulse when the quadword store is complete |
| busy | output | 1 | A quadword store is in progress |
| bad_form | output | 1 | One-cycle pulse when a request names an odd register |

## Verification
Some properties are checked on every cycle by the assertions:

- a stalled beat holds its address and data;
- the second address is always eight above the first accepted one;
- done follows only an accepted beat and never lasts two cycles;
- bad_form never coincides with a store in progress.

Other behaviour only the directed scenarios can show. These are the values of the effective address and the data in each endian mode, including negative displacements and the zero-base case. They also cover the rejection of odd register numbers without any beat, the ignoring of requests offered mid-store, and the abort by reset.

// File: rtl/qps_pkg.sv
// Package: shared types and helpers for the quadword pair store sequencer.
// Assumes byte-addressed memory and 8-bit bytes.
package qps_pkg;

    // Sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BEAT0 = 2'd1,
        ST_BEAT1 = 2'd2,
        ST_DONE  = 2'd3
    } qps_state_t;

    // Byte distance between the two doublewords.
    localparam int unsigned DWORD_BYTES = 8;

endpackage

// File: rtl/qps_addr_gen.sv
// Module: effective address generator.
// Forms base (or zero) plus the displacement, sign-extended and scaled by four.
// Also gives the address of the following doubleword.
// Assumes AW > DSW + 2.
module qps_addr_gen #(
    parameter int unsigned AW  = 64,
    parameter int unsigned DSW = 14
) (
    input  logic [AW-1:0]  base,
    input  logic           base_zero,
    input  logic [DSW-1:0] ds,
    output logic [AW-1:0]  addr_lo,
    output logic [AW-1:0]  addr_hi
);
    import qps_pkg::*;

    localparam int unsigned EXT_W = AW - DSW - 2;

    logic [AW-1:0] base_sel;
    logic [AW-1:0] disp;

    // Select the base and build the scaled, sign-extended displacement.
    always_comb begin
        base_sel = base_zero ? '0 : base;
        disp     = {{EXT_W{ds[DSW-1]}}, ds, 2'b00};
        addr_lo  = base_sel + disp;
        addr_hi  = addr_lo + AW'(DWORD_BYTES);
    end
endmodule

// File: rtl/qps_beat_mux.sv
// Module: beat data selector.
// Picks the register and byte order for a beat from the endian mode and the beat index.
// Big-endian: beat 0 is even, beat 1 is odd, bytes unmodified.
// Little-endian: beat 0 is odd, beat 1 is even, both byte-reversed.
// Assumes DW is a multiple of 8.
module qps_beat_mux #(
    parameter int unsigned DW = 64
) (
    input  logic [DW-1:0] even_val,
    input  logic [DW-1:0] odd_val,
    input  logic          little_endian,
    input  logic          sel_hi,
    output logic [DW-1:0] data
);
    localparam int unsigned NB = DW / 8;

    logic [DW-1:0] even_rev;
    logic [DW-1:0] odd_rev;

    // Byte lanes of the reversed copies.
    for (genvar k = 0; k < NB; k++) begin : g_lane
        assign even_rev[8*k +: 8] = even_val[8*(NB-1-k) +: 8];
        assign odd_rev[8*k +: 8]  = odd_val[8*(NB-1-k) +: 8];
    end

    // Choose the beat word from the mode and the beat index.
    always_comb begin
        case ({little_endian, sel_hi})
            2'b00:   data = even_val;
            2'b01:   data = odd_val;
            2'b10:   data = odd_rev;
            default: data = even_rev;
        endcase
    end
endmodule

// File: rtl/qw_pair_store.sv
// Module: quadword register-pair store sequencer (top).
// Takes one request and issues two doubleword write beats in ascending address order.
// The second beat waits for the first to be accepted. done pulses at the end.
// Odd register numbers are rejected with bad_form.
// Assumes a synchronous active-low reset and a single clock.
module qw_pair_store #(
    parameter int unsigned AW   = 64,
    parameter int unsigned DW   = 64,
    parameter int unsigned REGW = 5,
    parameter int unsigned DSW  = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [REGW-1:0] req_reg,
    input  logic [DW-1:0]   req_even_val,
    input  logic [DW-1:0]   req_odd_val,
    input  logic [AW-1:0]   req_base,
    input  logic [DSW-1:0]  req_ds,
    input  logic            req_base_zero,
    input  logic            req_little_endian,
    output logic            wr_valid,
    input  logic            wr_ready,
    output logic [AW-1:0]   wr_addr,
    output logic [DW-1:0]   wr_data,
    output logic            done,
    output logic            busy,
    output logic            bad_form
);
    import qps_pkg::*;

    qps_state_t     state_q;
    logic [DW-1:0]  even_q, odd_q;
    logic [AW-1:0]  base_q;
    logic [DSW-1:0] ds_q;
    logic           zero_q, le_q;
    logic [AW-1:0]  addr_lo, addr_hi;
    logic           accept;

    assign accept = req_valid && (state_q == ST_IDLE);

    // State transitions and the invalid-form pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            bad_form <= 1'b0;
        end else begin
            bad_form <= accept && req_reg[0];
            case (state_q)
                ST_IDLE:  if (accept && !req_reg[0]) state_q <= ST_BEAT0;
                ST_BEAT0: if (wr_ready) state_q <= ST_BEAT1;
                ST_BEAT1: if (wr_ready) state_q <= ST_DONE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Capture the request operands on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            even_q <= '0;
            odd_q  <= '0;
            base_q <= '0;
            ds_q   <= '0;
            zero_q <= 1'b0;
            le_q   <= 1'b0;
        end else if (accept) begin
            even_q <= req_even_val;
            odd_q  <= req_odd_val;
            base_q <= req_base;
            ds_q   <= req_ds;
            zero_q <= req_base_zero;
            le_q   <= req_little_endian;
        end
    end

    qps_addr_gen #(.AW(AW), .DSW(DSW)) i_addr (
        .base      (base_q),
        .base_zero (zero_q),
        .ds        (ds_q),
        .addr_lo   (addr_lo),
        .addr_hi   (addr_hi)
    );

    qps_beat_mux #(.DW(DW)) i_mux (
        .even_val      (even_q),
        .odd_val       (odd_q),
        .little_endian (le_q),
        .sel_hi        (state_q == ST_BEAT1),
        .data          (wr_data)
    );

    // Port outputs decoded from the state.
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        busy      = (state_q != ST_IDLE);
        wr_valid  = (state_q == ST_BEAT0) || (state_q == ST_BEAT1);
        done      = (state_q == ST_DONE);
        wr_addr   = (state_q == ST_BEAT1) ? addr_hi : addr_lo;
    end

    // R6: a stalled beat keeps its address and data.
    a_r6_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    // R3: the beat after the first accepted one is eight bytes higher.
    a_r3_second_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready && state_q == ST_BEAT0) |=>
        (wr_valid && wr_addr == $past(wr_addr) + AW'(DWORD_BYTES)));

    // R9: done only follows an accepted beat and lasts one cycle.
    a_r9_done_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(wr_valid && wr_ready));

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: a rejected request never overlaps a store in progress.
    a_r7_bad_idle: assert property (@(posedge clk) disable iff (!rst_n)
        bad_form |-> (!busy && !wr_valid));

    // R8: once busy, req_ready stays low until done.
    a_r8_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

// File: tb/test_qw_pair_store.sv
`timescale 1ns/1ps
module test_qw_pair_store;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready;
    logic [4:0]  req_reg;
    logic [63:0] req_even_val, req_odd_val, req_base;
    logic [13:0] req_ds;
    logic        req_base_zero, req_little_endian;
    logic        wr_valid, wr_ready;
    logic [63:0] wr_addr, wr_data;
    logic        done, busy, bad_form;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #10 clk = ~clk;

    qw_pair_store i_qw_pair_store (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_reg(req_reg), .req_even_val(req_even_val), .req_odd_val(req_odd_val),
        .req_base(req_base), .req_ds(req_ds), .req_base_zero(req_base_zero),
        .req_little_endian(req_little_endian), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data), .done(done), .busy(busy), .bad_form(bad_form)
    );

    function automatic logic [63:0] brev(input logic [63:0] x);
        logic [63:0] r;
        for (int k = 0; k < 8; k++) r[8*k +: 8] = x[8*(7-k) +: 8];
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Full store scenario: request, two beats with stalls, done, return to idle.
    task automatic do_store(input logic [4:0] rn, input logic [63:0] ev, input logic [63:0] od,
                            input logic [63:0] b, input logic [13:0] ds, input logic z,
                            input logic le, input int st0, input int st1, input logic inject);
        logic [63:0] ea, d0, d1;
        ea = (z ? 64'd0 : b) + {{48{ds[13]}}, ds, 2'b00};
        d0 = le ? brev(od) : ev;
        d1 = le ? brev(ev) : od;
        @(negedge clk);
        check("R10 ready before request", {63'd0, req_ready}, 64'd1);
        req_reg = rn; req_even_val = ev; req_odd_val = od; req_base = b;
        req_ds = ds; req_base_zero = z; req_little_endian = le; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R8 busy after accept", {62'd0, busy, req_ready}, 64'd2);
        check("R1 beat0 address", wr_addr, ea);
        check(le ? "R4 beat0 data" : "R2 beat0 data", wr_data, d0);
        for (int i = 0; i < st0; i++) begin
            if (inject) begin
                req_valid = 1'b1; req_reg = 5'd3; req_even_val = ~ev; req_odd_val = ~od;
                req_base = ~b; req_little_endian = ~le;
            end
            @(negedge clk);
            check("R6 beat0 held valid", {63'd0, wr_valid}, 64'd1);
            check("R6 beat0 held addr", wr_addr, ea);
            check("R6 beat0 held data", wr_data, d0);
            if (inject) check("R8 ignored request no bad_form", {63'd0, bad_form}, 64'd0);
        end
        req_valid = 1'b0;
        wr_ready = 1'b1;
        @(negedge clk);
        wr_ready = 1'b0;
        check("R3 beat1 address", wr_addr, ea + 64'd8);
        check(le ? "R5 beat1 data" : "R3 beat1 data", wr_data, d1);
        check("R3 beat1 valid", {63'd0, wr_valid}, 64'd1);
        for (int i = 0; i < st1; i++) begin
            @(negedge clk);
            check("R6 beat1 held addr", wr_addr, ea + 64'd8);
            check("R6 beat1 held data", wr_data, d1);
        end
        wr_ready = 1'b1;
        @(negedge clk);
        wr_ready = 1'b0;
        check("R9 done pulse", {61'd0, done, busy, wr_valid}, 64'd6);
        @(negedge clk);
        check("R9 idle after done", {61'd0, done, busy, req_ready}, 64'd1);
    endtask

    // Odd register number: rejected, no beat.
    task automatic do_bad(input logic [4:0] rn);
        @(negedge clk);
        req_reg = rn; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R7 bad_form raised", {61'd0, bad_form, busy, wr_valid}, 64'd4);
        @(negedge clk);
        check("R7 bad_form one cycle", {61'd0, bad_form, busy, wr_valid}, 64'd0);
    endtask

    // Reset at start and in the middle of a store.
    task automatic do_reset_mid();
        @(negedge clk);
        req_reg = 5'd4; req_base = 64'h100; req_ds = 14'd1; req_base_zero = 1'b0;
        req_little_endian = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R10 reset aborts store",
              {59'd0, wr_valid, done, busy, bad_form, req_ready}, 64'd1);
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; wr_ready = 1'b0; req_reg = '0;
        req_even_val = '0; req_odd_val = '0; req_base = '0; req_ds = '0;
        req_base_zero = 1'b0; req_little_endian = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 reset state", {59'd0, wr_valid, done, busy, bad_form, req_ready}, 64'd1);
        rst_n = 1'b1;
        do_store(5'd2, 64'h0011223344556677, 64'h8899AABBCCDDEEFF, 64'h1000, 14'd4, 1'b0, 1'b0, 0, 0, 1'b0);
        do_store(5'd6, 64'h0102030405060708, 64'hF1F2F3F4F5F6F7F8, 64'h2000, 14'h3FFE, 1'b0, 1'b1, 2, 1, 1'b0);
        do_store(5'd8, 64'hDEADBEEF00C0FFEE, 64'h1234567890ABCDEF, 64'hFFFF, 14'h2000, 1'b1, 1'b0, 3, 2, 1'b1);
        do_store(5'd30, 64'hA5A5_0000_5A5A_FFFF, 64'h0F0E0D0C0B0A0908, 64'hFFFF_FFFF_FFFF_FFF8, 14'd1, 1'b0, 1'b1, 1, 0, 1'b1);
        do_bad(5'd1);
        do_bad(5'd31);
        do_reset_mid();
        do_store(5'd0, 64'h1, 64'h2, 64'h0, 14'h1FFF, 1'b0, 1'b0, 0, 3, 1'b0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected below 20000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule